// File: doc/BRIEF.md
# Flash Controller Register and Interrupt Front End

This block is the software-facing register file of a flash controller. A simple 32-bit bus with a write strobe, a 12-bit byte address and write data reaches its registers. Read data is a combinational function of the address. The block holds the following:

- a command word, whose write launches a one-cycle start pulse;
- an 18-bit range start address and an 18-bit range stop address;
- a write-only event register that fires reset, wakeup and abort pulses;
- a constant identification word;
- a four-source interrupt unit.

The execution engine, the flash array and the ECC decoder are outside the block. They report back through four single-cycle event strobes: command failed, illegal command, command done and ECC error. Each strobe latches a status bit.

Enable and status bits are never written directly. Software changes them through dedicated write-one-to-set and write-one-to-clear addresses, so two agents can never lose each other's updates through a read-modify-write race. A single level interrupt output is high while any latched status bit has its enable set.

Top module: `fctl_regif`

## Requirements
- R1: After a synchronous active-low reset, all of the following are zero: status bits, enable bits, both range addresses, the command word, irq and every pulse output.
- R2: A write to offset 0x000 stores the 32-bit data on `cmd_word` and drives `cmd_start` high for exactly the one cycle that follows the write edge. A read of 0x000 returns zero.
- R3: Offsets 0x010 (range start) and 0x014 (range stop) store data bits 17:0. They read back with bits 31:18 zero. The stop address names the last word included in the range.
- R4: A write to offset 0x004 produces one-cycle pulses in the cycle after the write edge. Data bit 0 drives `req_reset`, bit 1 drives `req_wakeup` and bit 2 drives `req_abort`. A read of 0x004 returns zero.
- R5: Writing ones to 0xFDC sets enable bits, and writing ones to 0xFD8 clears them. Zero bits leave the enables unchanged. Enables read at 0xFE4, bits 3:0.
- R6: Writing ones to 0xFEC sets status bits, and writing ones to 0xFE8 clears them. Zero bits leave the status unchanged. Status reads at 0xFE0, bits 3:0.
- R7: Status bit order is: bit 0 command failed (`ev_fail`), bit 1 illegal command (`ev_illegal`), bit 2 command done (`ev_done`), bit 3 ECC error (`ev_ecc`). A high event input sets its bit at the next edge.
- R8: When an event input or a software set meets a software clear on the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly while some status bit and its enable bit are both set.
- R10: Offset 0xFFC reads as follows: aperture in bits 7:0, minor revision in 11:8, major revision in 15:12 and identifier in 31:16. All of these come from parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_fail | input | 1 | Engine strobe: legal command failed |
| ev_illegal | input | 1 | Engine strobe: illegal command seen |
| ev_done | input | 1 | Engine strobe: command finished |
| ev_ecc | input | 1 | Decoder strobe: ECC error on a read |
| cmd_start | output | 1 | One-cycle pulse after a command write |
| cmd_word | output | 32 | Last command word written |
| range_start | output | 18 | First word address of the operation |
| range_stop | output | 18 | Last word address of the operation, inclusive |
| req_reset | output | 1 | One-cycle controller and flash reset request |
| req_wakeup | output | 1 | One-cycle wakeup request |
| req_abort | output | 1 | One-cycle abort of program or erase |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives random mixes of set and clear writes to the enable and status addresses. It also drives random event strobes in the same cycles, including a clear hitting a bit that an event sets at the same edge. A design that let the clear win would lose an event. A design that treated a written zero as a clear would wipe bits other agents had set.

Directed cases cover the following:
- the exact cycle and the width of every pulse, where an off-by-one register would show a late or two-cycle pulse;
- the zero readback of the write-only offsets;
- truncation of the range registers to 18 bits;
- the identification fields, where a swapped field shows at once.

// File: rtl/fctl_pkg.sv
// Package: shared constants of the flash controller register front end.
// Assumes byte addressing with word-aligned accesses on a 12-bit window.
package fctl_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int RANGE_W = 18;
    localparam int N_IRQ = 4;
    localparam int N_EVT = 3;

    localparam logic [ADDR_W-1:0] OFS_CMD      = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EVT      = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_RSTART   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RSTOP    = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'hFD8;
    localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'hFDC;
    localparam logic [ADDR_W-1:0] OFS_STAT     = 12'hFE0;
    localparam logic [ADDR_W-1:0] OFS_EN       = 12'hFE4;
    localparam logic [ADDR_W-1:0] OFS_STAT_CLR = 12'hFE8;
    localparam logic [ADDR_W-1:0] OFS_STAT_SET = 12'hFEC;
    localparam logic [ADDR_W-1:0] OFS_IDENT    = 12'hFFC;

    // interrupt source bit positions (software decodes these)
    localparam int IRQ_FAIL = 0;
    localparam int IRQ_ILLEGAL = 1;
    localparam int IRQ_DONE = 2;
    localparam int IRQ_ECC = 3;

    // event pulse bit positions
    localparam int EVT_RESET = 0;
    localparam int EVT_WAKEUP = 1;
    localparam int EVT_ABORT = 2;
endpackage

// File: rtl/fctl_sticky_bit.sv
// Module: one sticky bit with set and clear requests.
// Assumes set and clear are single-cycle qualified strobes; set has priority.
module fctl_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // holds the bit; a set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end
endmodule

// File: rtl/fctl_irq_unit.sv
// Module: interrupt enables and status with separate set/clear write ports.
// Assumes decoded one-cycle write strobes and hardware strobes from the engine.
module fctl_irq_unit #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_set_wr,
    input  logic         en_clr_wr,
    input  logic         st_set_wr,
    input  logic         st_clr_wr,
    input  logic [N-1:0] wmask,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] enable_o,
    output logic [N-1:0] status_o,
    output logic         irq_o
);
    // one enable cell and one status cell per source
    for (genvar i = 0; i < N; i++) begin : g_src
        logic en_set, en_clr, st_set, st_clr;

        // per-bit qualification of the write masks
        always_comb begin
            en_set = en_set_wr & wmask[i];
            en_clr = en_clr_wr & wmask[i];
            st_set = (st_set_wr & wmask[i]) | hw_set[i];
            st_clr = st_clr_wr & wmask[i];
        end

        fctl_sticky_bit u_en (
            .clk(clk), .rst_n(rst_n), .set_i(en_set), .clr_i(en_clr), .q_o(enable_o[i])
        );
        fctl_sticky_bit u_st (
            .clk(clk), .rst_n(rst_n), .set_i(st_set), .clr_i(st_clr), .q_o(status_o[i])
        );
    end

    // request is any enabled pending source
    always_comb irq_o = |(enable_o & status_o);
endmodule

// File: rtl/fctl_ctrl_regs.sv
// Module: command word, range addresses and event pulses.
// Assumes decoded one-cycle write strobes; pulses are registered, one cycle wide.
module fctl_ctrl_regs #(
    parameter int DW = 32,
    parameter int RW = 18,
    parameter int NE = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic          evt_wr,
    input  logic          rstart_wr,
    input  logic          rstop_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cmd_word_o,
    output logic          cmd_start_o,
    output logic [RW-1:0] rstart_o,
    output logic [RW-1:0] rstop_o,
    output logic [NE-1:0] evt_pulse_o
);
    // command word and its start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_word_o  <= '0;
            cmd_start_o <= 1'b0;
        end else begin
            cmd_start_o <= cmd_wr;
            if (cmd_wr)
                cmd_word_o <= wdata;
        end
    end

    // range start and stop address holders
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rstart_o <= '0;
            rstop_o  <= '0;
        end else begin
            if (rstart_wr)
                rstart_o <= wdata[RW-1:0];
            if (rstop_wr)
                rstop_o <= wdata[RW-1:0];
        end
    end

    // one pulse cell per event bit
    for (genvar e = 0; e < NE; e++) begin : g_evt
        always_ff @(posedge clk) begin
            if (!rst_n)
                evt_pulse_o[e] <= 1'b0;
            else
                evt_pulse_o[e] <= evt_wr & wdata[e];
        end
    end
endmodule

// File: rtl/fctl_regif.sv
// Module: top of the flash controller register front end.
// Decodes bus writes, muxes read data and joins the control and interrupt parts.
// Assumes word-aligned addresses; unmapped and write-only offsets read zero.
module fctl_regif #(
    parameter logic [15:0] ID_CODE   = 16'hF1C0,
    parameter logic [3:0]  REV_MAJOR = 4'd2,
    parameter logic [3:0]  REV_MINOR = 4'd1,
    parameter logic [7:0]  APERTURE  = 8'h10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ev_fail,
    input  logic        ev_illegal,
    input  logic        ev_done,
    input  logic        ev_ecc,
    output logic        cmd_start,
    output logic [31:0] cmd_word,
    output logic [17:0] range_start,
    output logic [17:0] range_stop,
    output logic        req_reset,
    output logic        req_wakeup,
    output logic        req_abort,
    output logic        irq
);
    import fctl_pkg::*;

    localparam logic [DATA_W-1:0] IDENT_WORD = {ID_CODE, REV_MAJOR, REV_MINOR, APERTURE};

    logic                wr_cmd, wr_evt, wr_rstart, wr_rstop;
    logic                wr_en_set, wr_en_clr, wr_st_set, wr_st_clr;
    logic [N_IRQ-1:0]    hw_set;
    logic [N_IRQ-1:0]    irq_enable;
    logic [N_IRQ-1:0]    irq_status;
    logic [N_EVT-1:0]    evt_pulse;

    // write strobe decode
    always_comb begin
        wr_cmd    = bus_wr && (bus_addr == OFS_CMD);
        wr_evt    = bus_wr && (bus_addr == OFS_EVT);
        wr_rstart = bus_wr && (bus_addr == OFS_RSTART);
        wr_rstop  = bus_wr && (bus_addr == OFS_RSTOP);
        wr_en_set = bus_wr && (bus_addr == OFS_EN_SET);
        wr_en_clr = bus_wr && (bus_addr == OFS_EN_CLR);
        wr_st_set = bus_wr && (bus_addr == OFS_STAT_SET);
        wr_st_clr = bus_wr && (bus_addr == OFS_STAT_CLR);
    end

    // hardware event strobes placed at their status bit positions
    always_comb begin
        hw_set              = '0;
        hw_set[IRQ_FAIL]    = ev_fail;
        hw_set[IRQ_ILLEGAL] = ev_illegal;
        hw_set[IRQ_DONE]    = ev_done;
        hw_set[IRQ_ECC]     = ev_ecc;
    end

    fctl_ctrl_regs #(.DW(DATA_W), .RW(RANGE_W), .NE(N_EVT)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(wr_cmd), .evt_wr(wr_evt), .rstart_wr(wr_rstart), .rstop_wr(wr_rstop),
        .wdata(bus_wdata),
        .cmd_word_o(cmd_word), .cmd_start_o(cmd_start),
        .rstart_o(range_start), .rstop_o(range_stop),
        .evt_pulse_o(evt_pulse)
    );

    fctl_irq_unit #(.N(N_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .en_set_wr(wr_en_set), .en_clr_wr(wr_en_clr),
        .st_set_wr(wr_st_set), .st_clr_wr(wr_st_clr),
        .wmask(bus_wdata[N_IRQ-1:0]), .hw_set(hw_set),
        .enable_o(irq_enable), .status_o(irq_status), .irq_o(irq)
    );

    // event pulse fan-out
    always_comb begin
        req_reset  = evt_pulse[EVT_RESET];
        req_wakeup = evt_pulse[EVT_WAKEUP];
        req_abort  = evt_pulse[EVT_ABORT];
    end

    // read data mux; write-only and unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RSTART: bus_rdata[RANGE_W-1:0] = range_start;
            OFS_RSTOP:  bus_rdata[RANGE_W-1:0] = range_stop;
            OFS_STAT:   bus_rdata[N_IRQ-1:0]   = irq_status;
            OFS_EN:     bus_rdata[N_IRQ-1:0]   = irq_enable;
            OFS_IDENT:  bus_rdata              = IDENT_WORD;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// Checker: temporal properties of the register front end, bound to the top.
module fctl_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic [3:0]  hw_set,
    input logic [3:0]  irq_enable,
    input logic [3:0]  irq_status,
    input logic        cmd_start,
    input logic        req_abort,
    input logic        irq
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_status == 4'd0 && irq_enable == 4'd0 && !cmd_start && !irq));

    assert_start_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'h000) |=> cmd_start);

    assert_no_spurious_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 12'h000) |=> !cmd_start);

    assert_abort_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 12'h004 && bus_wdata[2]) |=> !req_abort);

    assert_enable_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'hFDC) |=> ((irq_enable & $past(bus_wdata[3:0])) == $past(bus_wdata[3:0])));

    assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 12'hFE8 && hw_set == 4'd0) |=> ((irq_status & $past(bus_wdata[3:0])) == 4'd0));

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != 4'd0) |=> ((irq_status & $past(hw_set)) == $past(hw_set)));

    assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status == 4'd0) |-> !irq);
endmodule

bind fctl_regif fctl_regif_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .hw_set(hw_set), .irq_enable(irq_enable), .irq_status(irq_status),
    .cmd_start(cmd_start), .req_abort(req_abort), .irq(irq)
);

// File: tb/sim_fctl_regif.sv
// Bench: directed corners plus seeded random set/clear/event traffic.
module sim_fctl_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_fail = 1'b0, ev_illegal = 1'b0, ev_done = 1'b0, ev_ecc = 1'b0;
    logic        cmd_start;
    logic [31:0] cmd_word;
    logic [17:0] range_start, range_stop;
    logic        req_reset, req_wakeup, req_abort, irq;

    int errors = 0;
    int checks = 0;
    logic [3:0] m_en = '0;
    logic [3:0] m_st = '0;

    always #4 clk = ~clk;

    fctl_regif u0 (.*);

    // expected status after one edge: set (software or event) beats clear
    function automatic logic [3:0] next_status(logic [3:0] cur, logic [3:0] set, logic [3:0] clr);
        return (cur & ~clr) | set;
    endfunction

    function automatic logic exp_irq(logic [3:0] st, logic [3:0] en);
        return |(st & en);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock with an optional write and event strobes {ecc,done,illegal,fail}
    task automatic cycle(logic wr, logic [11:0] a, logic [31:0] d, logic [3:0] ev);
        logic [3:0] s, c;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        {ev_ecc, ev_done, ev_illegal, ev_fail} = ev;
        s = ev; c = '0;
        if (wr && a == 12'hFEC) s = s | d[3:0];
        if (wr && a == 12'hFE8) c = d[3:0];
        if (wr && a == 12'hFDC) m_en = m_en | d[3:0];
        if (wr && a == 12'hFD8) m_en = m_en & ~d[3:0];
        m_st = next_status(m_st, s, c);
        @(negedge clk);
        bus_wr = 1'b0;
        {ev_ecc, ev_done, ev_illegal, ev_fail} = 4'd0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(12'hFE0, v); check("R1 status", v, 0);
        rd(12'hFE4, v); check("R1 enable", v, 0);
        check("R1 outputs", {cmd_start, req_reset, req_wakeup, req_abort, irq}, 0);
        rd(12'h010, v); check("R1 range_start", v, 0);
        rst_n = 1'b1;

        // R2: command pulse visible right after the write edge, one cycle only
        @(negedge clk);
        bus_wr = 1; bus_addr = 12'h000; bus_wdata = 32'hA5C3_0F17;
        @(negedge clk); bus_wr = 0;
        check("R2 start pulse", cmd_start, 1);
        check("R2 command word", cmd_word, 32'hA5C3_0F17);
        rd(12'h000, v); check("R2 read zero", v, 0);
        @(negedge clk);
        check("R2 pulse width", cmd_start, 0);

        // R3: 18-bit ranges
        cycle(1, 12'h010, 32'hFFFF_FFFF, 0);
        cycle(1, 12'h014, 32'h0002_1234, 0);
        rd(12'h010, v); check("R3 start truncated", v, 32'h0003_FFFF);
        rd(12'h014, v); check("R3 stop", v, 32'h0002_1234);
        check("R3 stop port", range_stop, 18'h2_1234);

        // R4: event pulses
        @(negedge clk);
        bus_wr = 1; bus_addr = 12'h004; bus_wdata = 32'h0000_0005;
        @(negedge clk); bus_wr = 0;
        check("R4 pulses", {req_abort, req_wakeup, req_reset}, 3'b101);
        rd(12'h004, v); check("R4 read zero", v, 0);
        @(negedge clk);
        check("R4 pulse width", {req_abort, req_wakeup, req_reset}, 3'b000);
        cycle(1, 12'h004, 32'h0000_0002, 0);

        // R10: identification word
        rd(12'hFFC, v); check("R10 ident", v, 32'hF1C0_2110);

        // R7: each event lands on its own bit
        for (int i = 0; i < 4; i++) begin
            cycle(0, 12'h000, 0, 4'(1 << i));
            rd(12'hFE0, v); check("R7 event bit", v, {28'd0, m_st});
            cycle(1, 12'hFE8, 32'hF, 0);
        end

        // R8: clear and event on the same bit in the same cycle
        cycle(1, 12'hFEC, 32'h6, 0);
        cycle(1, 12'hFE8, 32'hF, 4'b0100);
        rd(12'hFE0, v); check("R8 set wins", v, 32'h4);

        // R5/R6: zero bits have no effect
        cycle(1, 12'hFDC, 32'h9, 0);
        cycle(1, 12'hFD8, 32'h0, 0);
        rd(12'hFE4, v); check("R5 zero clear ignored", v, 32'h9);
        cycle(1, 12'hFE8, 32'h0, 0);
        rd(12'hFE0, v); check("R6 zero clear ignored", v, 32'h4);
        check("R9 masked", irq, 0);
        cycle(1, 12'hFDC, 32'h4, 0);
        check("R9 enabled", irq, 1);

        // random traffic
        void'($urandom(32'd1207));
        for (int n = 0; n < 400; n++) begin
            logic [11:0] a;
            logic [3:0] ev;
            int k;
            k = $urandom_range(0, 3);
            a = (k == 0) ? 12'hFDC : (k == 1) ? 12'hFD8 : (k == 2) ? 12'hFEC : 12'hFE8;
            ev = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'd0;
            cycle($urandom_range(0, 4) != 0, a, $urandom, ev);
            rd(12'hFE0, v); check("R6 R7 R8 random status", v, {28'd0, m_st});
            rd(12'hFE4, v); check("R5 random enable", v, {28'd0, m_en});
            check("R9 random irq", irq, exp_irq(m_st, m_en));
        end

        // R1: reset again from a busy state
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(12'hFE0, v); check("R1 status after reset", v, 0);
        check("R1 irq after reset", irq, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule